// File: doc/BRIEF.md
# Sequence-Aware Clock Period Selector

This block sits beside an instruction issue stage and picks, on every clock cycle, the period the adaptive clock generator should use next. Each issued instruction comes with a 2-bit kind code. The block keeps the kinds of the last few valid instructions. From that recent mix it decides which period column applies. Windows made only of simple logic and arithmetic operations need the least margin. Windows holding a load, a store or a branch need more. Windows holding a multiply or divide use the longest column.

The period comes from a small writable table. The table is indexed by the sequence column and by a 4-bit operating-corner bin supplied by an external voltage and temperature monitor. After reset, or whenever the monitor reports its bin as untrustworthy, the block falls back to a programmable worst-case period. It stays there until the window holds a full set of fresh instructions. The table also has default contents, so the block gives useful periods before any software programming.

Top module: `seq_period_sel`

## Requirements
- R1: `instr_kind` is encoded as 0 = logic/arithmetic, 1 = memory, 2 = multiply/divide, 3 = control flow. The window holds the kinds of the last 4 cycles with `instr_valid` high. A cycle with `instr_valid` low leaves the window unchanged.
- R2: With a full window of only kind 0, `period_req` is the light column (column 0) entry of the current corner bin.
- R3: With a full window that holds a kind 1 or kind 3 entry and no kind 2 entry, `period_req` is the heavy column (column 1) entry.
- R4: With a full window that holds any kind 2 entry, `period_req` is the multiply/divide column (column 2) entry.
- R5: `period_req` is registered. It changes only at the rising edge that samples the instruction altering the window, and it never changes combinationally with the inputs.
- R6: After reset, `period_req` is the worst-case period until 4 valid instructions have been accepted while `corner_ok` is high. The edge that samples the 4th of them already yields the table entry.
- R7: In any cycle with `corner_ok` low, the next `period_req` is the worst-case period, and the fill count returns to zero. 4 further valid instructions with `corner_ok` high are then needed before table entries are used again.
- R8: A table write sets the entry at bin `tbl_corner` and column `tbl_col` (0..2). Writing column 3 loads the worst-case period register. A lookup in the same cycle as a write still returns the old entry; the new value is used from the next cycle.
- R9: Defaults, in units of 10 ps: bin 6 holds 128 / 135 / 140 and bin 2 holds 180 / 186 / 195 (light / heavy / multiply-divide). Every other entry holds 250, and the worst-case register resets to 250. Reset clears the worst-case register back to 250 but does not restore table contents.
- R10: A change of `corner_code` while `corner_ok` stays high takes effect at the next edge without refilling the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is issued this cycle |
| instr_kind | input | 2 | Kind code of the issued instruction |
| corner_code | input | 4 | Quantized voltage/temperature bin |
| corner_ok | input | 1 | Corner bin is trustworthy |
| tbl_we | input | 1 | Table write enable |
| tbl_corner | input | 4 | Bin of the table entry to write |
| tbl_col | input | 2 | Column to write (3 selects the worst-case register) |
| tbl_data | input | 12 | Period to write, in units of 10 ps |
| period_req | output | 12 | Requested clock period, in units of 10 ps |

## Verification
Every result of this block is due exactly one rising edge after the cycle that presents the stimulus. This applies to an instruction entering the window, a corner change, a `corner_ok` drop and a table write becoming visible. The bench changes inputs on the falling edge and reads `period_req` 1 ns after the following rising edge, so each check sees the value that edge produced. For the registered-output requirement it also reads the output just after driving a new instruction, before the edge, and expects the previous value. The same-cycle write check reads the edge that performs the write and expects the old entry. The following edge is then expected to show the new entry.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_MEM    = 2'd1,
    K_MULDIV = 2'd2,
    K_CTRL   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    COL_LIGHT  = 2'd0,
    COL_HEAVY  = 2'd1,
    COL_MULDIV = 2'd2,
    COL_WORST  = 2'd3
  } col_e;
endpackage

// File: rtl/sps_window.sv
module sps_window
  import sps_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  kind_e in_kind,
  input  logic  clear,
  output col_e  nxt_col,
  output logic  nxt_full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][1:0] hist_q, hist_d;
  logic [CW-1:0]         fill_q, fill_d;
  logic [DEPTH-1:0]      md_bit, heavy_bit;

  always_comb begin
    hist_d = hist_q;
    if (in_valid) hist_d = {hist_q[DEPTH-2:0], in_kind};
  end

  always_comb begin
    if (clear)                                  fill_d = '0;
    else if (in_valid && fill_q != CW'(DEPTH))  fill_d = fill_q + 1'b1;
    else                                        fill_d = fill_q;
  end

  // Per-slot class flags over the post-update window
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign md_bit[g]    = (hist_d[g] == K_MULDIV);
    assign heavy_bit[g] = (hist_d[g] == K_MEM) || (hist_d[g] == K_CTRL);
  end

  always_comb begin
    if (|md_bit)         nxt_col = COL_MULDIV;
    else if (|heavy_bit) nxt_col = COL_HEAVY;
    else                 nxt_col = COL_LIGHT;
  end

  assign nxt_full = (fill_d == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(hist_q)); // R1
  AST_MULDIV_WINS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == K_MULDIV) |-> nxt_col == COL_MULDIV); // R4
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clear && fill_q != CW'(DEPTH)) |=> fill_q == $past(fill_q) + 1'b1); // R6
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clear |=> fill_q == '0); // R7
endmodule

// File: rtl/sps_period_table.sv
module sps_period_table
  import sps_pkg::*;
#(
  parameter int CORNER_W   = 4,
  parameter int PERIOD_W   = 12,
  parameter int WORST_INIT = 250,
  parameter int BIN_MID    = 6,
  parameter int MID_LIGHT  = 128,
  parameter int MID_HEAVY  = 135,
  parameter int MID_MULDIV = 140,
  parameter int BIN_LOW    = 2,
  parameter int LOW_LIGHT  = 180,
  parameter int LOW_HEAVY  = 186,
  parameter int LOW_MULDIV = 195
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [CORNER_W-1:0] wr_corner,
  input  col_e                wr_col,
  input  logic [PERIOD_W-1:0] wdata,
  input  logic [CORNER_W-1:0] rd_corner,
  input  col_e                rd_col,
  input  logic                use_table,
  output logic [PERIOD_W-1:0] period_q
);
  localparam int AW      = CORNER_W + 2;
  localparam int ENTRIES = 1 << AW;

  logic [PERIOD_W-1:0] mem [ENTRIES];
  logic [PERIOD_W-1:0] worst_q;
  logic [AW-1:0]       wr_addr, rd_addr;
  logic                tbl_wr;

  function automatic logic [PERIOD_W-1:0] seed(int idx);
    int bin = idx >> 2;
    int col = idx & 3;
    int v   = WORST_INIT;
    if (bin == BIN_MID) v = (col == 0) ? MID_LIGHT : (col == 1) ? MID_HEAVY :
                            (col == 2) ? MID_MULDIV : WORST_INIT;
    if (bin == BIN_LOW) v = (col == 0) ? LOW_LIGHT : (col == 1) ? LOW_HEAVY :
                            (col == 2) ? LOW_MULDIV : WORST_INIT;
    return PERIOD_W'(v);
  endfunction

  initial begin
    for (int i = 0; i < ENTRIES; i++) mem[i] = seed(i);
  end

  assign wr_addr = {wr_corner, wr_col};
  assign rd_addr = {rd_corner, rd_col};
  assign tbl_wr  = we && (wr_col != COL_WORST);

  always_ff @(posedge clk) begin
    if (tbl_wr) mem[wr_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                             worst_q <= PERIOD_W'(WORST_INIT);
    else if (we && wr_col == COL_WORST)  worst_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)            period_q <= PERIOD_W'(WORST_INIT);
    else if (use_table) period_q <= mem[rd_addr];
    else                period_q <= worst_q;
  end

  AST_FALLBACK_WORST: assert property (@(posedge clk) disable iff (rst)
    !use_table |=> period_q == $past(worst_q)); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    tbl_wr |=> mem[$past(wr_addr)] == $past(wdata)); // R8
  AST_WORST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (we && wr_col == COL_WORST) |=> worst_q == $past(wdata)); // R8
endmodule

// File: rtl/seq_period_sel.sv
module seq_period_sel
  import sps_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int CORNER_W   = 4,
  parameter int PERIOD_W   = 12,
  parameter int WORST_INIT = 250
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [1:0]          instr_kind,
  input  logic [CORNER_W-1:0] corner_code,
  input  logic                corner_ok,
  input  logic                tbl_we,
  input  logic [CORNER_W-1:0] tbl_corner,
  input  logic [1:0]          tbl_col,
  input  logic [PERIOD_W-1:0] tbl_data,
  output logic [PERIOD_W-1:0] period_req
);
  col_e nxt_col;
  logic nxt_full;

  sps_window #(.DEPTH(DEPTH)) u_window (
    .clk      (clk),
    .rst      (rst),
    .in_valid (instr_valid),
    .in_kind  (kind_e'(instr_kind)),
    .clear    (!corner_ok),
    .nxt_col  (nxt_col),
    .nxt_full (nxt_full)
  );

  sps_period_table #(
    .CORNER_W   (CORNER_W),
    .PERIOD_W   (PERIOD_W),
    .WORST_INIT (WORST_INIT)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .we        (tbl_we),
    .wr_corner (tbl_corner),
    .wr_col    (col_e'(tbl_col)),
    .wdata     (tbl_data),
    .rd_corner (corner_code),
    .rd_col    (nxt_col),
    .use_table (nxt_full && corner_ok),
    .period_q  (period_req)
  );

  AST_REQ_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !instr_valid && !tbl_we && corner_ok && $stable(corner_code)
     && $past(corner_ok) && $past(!tbl_we)) |=> $stable(period_req)); // R5
endmodule

// File: tb/seq_period_sel_test.sv
module seq_period_sel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [1:0]  instr_kind = 2'd0;
  logic [3:0]  corner_code = 4'd6;
  logic        corner_ok = 1'b1;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_corner = 4'd0;
  logic [1:0]  tbl_col = 2'd0;
  logic [11:0] tbl_data = 12'd0;
  logic [11:0] period_req;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seq_period_sel uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_kind(instr_kind),
    .corner_code(corner_code), .corner_ok(corner_ok), .tbl_we(tbl_we),
    .tbl_corner(tbl_corner), .tbl_col(tbl_col), .tbl_data(tbl_data),
    .period_req(period_req)
  );

  // {req[23:20], valid[19], kind[18:17], corner[16:13], ok[12], expected[11:0]}
  localparam int NV = 25;
  localparam logic [23:0] VEC [NV] = '{
    {4'd6,  1'b1, 2'd0, 4'd6, 1'b1, 12'd250}, // R6 fill 1
    {4'd6,  1'b1, 2'd0, 4'd6, 1'b1, 12'd250}, // R6 fill 2
    {4'd6,  1'b1, 2'd0, 4'd6, 1'b1, 12'd250}, // R6 fill 3
    {4'd2,  1'b1, 2'd0, 4'd6, 1'b1, 12'd128}, // R2 full, all light
    {4'd1,  1'b0, 2'd0, 4'd6, 1'b1, 12'd128}, // R1 idle
    {4'd3,  1'b1, 2'd1, 4'd6, 1'b1, 12'd135}, // R3 memory enters
    {4'd3,  1'b1, 2'd0, 4'd6, 1'b1, 12'd135}, // R3
    {4'd3,  1'b1, 2'd0, 4'd6, 1'b1, 12'd135}, // R3
    {4'd1,  1'b1, 2'd0, 4'd6, 1'b1, 12'd135}, // R1 memory is oldest
    {4'd1,  1'b1, 2'd0, 4'd6, 1'b1, 12'd128}, // R1 memory left window
    {4'd4,  1'b1, 2'd2, 4'd6, 1'b1, 12'd140}, // R4 multiply
    {4'd4,  1'b1, 2'd3, 4'd6, 1'b1, 12'd140}, // R4 control behind multiply
    {4'd4,  1'b1, 2'd0, 4'd6, 1'b1, 12'd140}, // R4
    {4'd4,  1'b1, 2'd0, 4'd6, 1'b1, 12'd140}, // R4
    {4'd3,  1'b1, 2'd0, 4'd6, 1'b1, 12'd135}, // R3 control only
    {4'd2,  1'b1, 2'd0, 4'd6, 1'b1, 12'd128}, // R2
    {4'd10, 1'b1, 2'd0, 4'd2, 1'b1, 12'd180}, // R10 corner switch
    {4'd10, 1'b0, 2'd0, 4'd2, 1'b1, 12'd180}, // R10
    {4'd7,  1'b1, 2'd0, 4'd2, 1'b0, 12'd250}, // R7 corner untrusted
    {4'd7,  1'b1, 2'd0, 4'd2, 1'b1, 12'd250}, // R7 refill 1
    {4'd7,  1'b1, 2'd0, 4'd2, 1'b1, 12'd250}, // R7 refill 2
    {4'd7,  1'b1, 2'd0, 4'd2, 1'b1, 12'd250}, // R7 refill 3
    {4'd7,  1'b1, 2'd0, 4'd2, 1'b1, 12'd180}, // R7 refilled
    {4'd9,  1'b1, 2'd1, 4'd2, 1'b1, 12'd186}, // R9 bin 2 heavy
    {4'd9,  1'b1, 2'd2, 4'd2, 1'b1, 12'd195}  // R9 bin 2 multiply
  };

  task automatic check(input logic [11:0] exp, input int req, input string what);
    nvec++;
    if (period_req !== exp) begin
      nbad++;
      $display("FAIL R%0d %s: period_req=%0d expected=%0d", req, what, period_req, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [3:0] c,
                       input logic ok, input logic we, input logic [1:0] col,
                       input logic [11:0] d);
    @(negedge clk);
    instr_valid = v; instr_kind = k; corner_code = c; corner_ok = ok;
    tbl_we = we; tbl_corner = c; tbl_col = col; tbl_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(12'd250, 9, "reset value"); // R9
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18:17], VEC[i][16:13], VEC[i][12], 1'b0, 2'd0, 12'd0);
      check(VEC[i][11:0], int'(VEC[i][23:20]), $sformatf("vector %0d", i));
    end

    // R5: no combinational path; new value only after the sampling edge
    repeat (4) drive(1'b1, 2'd0, 4'd2, 1'b1, 1'b0, 2'd0, 12'd0);
    check(12'd180, 5, "light window at bin 2"); // R5
    @(negedge clk);
    instr_valid = 1'b1; instr_kind = 2'd2; #1;
    check(12'd180, 5, "before edge"); // R5
    @(posedge clk); #1;
    check(12'd195, 5, "after edge"); // R5
    repeat (4) drive(1'b1, 2'd0, 4'd2, 1'b1, 1'b0, 2'd0, 12'd0);
    check(12'd180, 5, "window cleared of multiply"); // R5

    // R8: same-cycle write returns old entry, new one next cycle
    drive(1'b0, 2'd0, 4'd2, 1'b1, 1'b1, 2'd0, 12'd170);
    check(12'd180, 8, "read during write"); // R8
    drive(1'b0, 2'd0, 4'd2, 1'b1, 1'b0, 2'd0, 12'd0);
    check(12'd170, 8, "read after write"); // R8
    drive(1'b0, 2'd0, 4'd2, 1'b1, 1'b1, 2'd3, 12'd300);
    check(12'd170, 8, "worst write keeps table output"); // R8
    drive(1'b0, 2'd0, 4'd2, 1'b0, 1'b0, 2'd0, 12'd0);
    check(12'd300, 8, "programmed worst used"); // R8

    // R9: reset restores worst register, keeps table
    @(negedge clk);
    rst = 1'b1; tbl_we = 1'b0; instr_valid = 1'b0; corner_ok = 1'b1;
    @(posedge clk); #1;
    check(12'd250, 9, "worst register after reset"); // R9
    @(negedge clk);
    rst = 1'b0;
    repeat (3) drive(1'b1, 2'd0, 4'd2, 1'b1, 1'b0, 2'd0, 12'd0);
    check(12'd250, 6, "still filling after reset"); // R6
    drive(1'b1, 2'd0, 4'd2, 1'b1, 1'b0, 2'd0, 12'd0);
    check(12'd170, 9, "table kept across reset"); // R9

    finish_run();
  end
endmodule